// File: doc/BRIEF.md
# Cascaded Two-Group Interrupt Aggregator

This block gathers 112 interrupt sources into a single host interrupt line. The sources are grouped into two masters, each holding seven blocks of eight inputs. Every input is watched for a rising edge. An edge sets a sticky latched bit, and that bit is qualified by a per-source mask bit. A host reaches all per-block state through a flat register port with a 16-bit address and 8-bit data. Each block has its own directly addressed registers for pending status, clear, mask and live input level. There is no indirect block selection.

Each master has a summary byte, and each of its bits flags one pending block. The summary of master 0 also carries a cascade flag in bit 0, which is set whenever any block of master 1 is pending. A host that reads the master 0 summary therefore learns in one access whether the master 1 summary needs a visit at all. The host interrupt output follows the master 0 summary.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every latched bit is 0, all summaries read 0x00 and `irq_o` is low.
- R2: A 0-to-1 change of a source sets its latched bit at the next clock edge. The bit stays set after the source falls. The pending register of block b (1..7) sits at group base + b and returns latched AND NOT mask.
- R3: Writing the clear register at group base + b + 1 clears each latched bit of block b whose data bit is 1. Data bits that are 0 leave their latched bits unchanged.
- R4: The mask register at group base + b + 8 is written and read back as a byte, where 1 masks and 0 unmasks. A masked source still latches, and it shows as pending once it is unmasked. Masking it again hides it without clearing it.
- R5: The real-time register at group base + b + 15 returns the live levels of block b's eight inputs, with bit i being input i.
- R6: The summary register sits at group base + 0 (0x130 for master 0, 0x1B0 for master 1). Its bit b (1..7) is 1 exactly when block b of that master has a nonzero pending register.
- R7: Bit 0 of the master 0 summary is 1 exactly when any of bits 7:1 of the master 1 summary is 1. Bit 0 of the master 1 summary reads 0.
- R8: `irq_o` is high exactly when the master 0 summary is nonzero.
- R9: Input bit i of block b in master m is source index ((m*7 + b - 1)*8) + i of `src_i`.
- R10: Reads of addresses with no readable register (including the clear addresses group base + 8) return 0x00. Writes to summary, block-1 pending and real-time addresses change no state.
- R11: When a rising edge and a clear of the same bit occur in the same cycle, the bit ends up latched. Other bits of the clear byte are cleared as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 112 | Interrupt source levels, synchronous to clk |
| reg_addr_i | input | 16 | Register address |
| reg_we_i | input | 1 | Write strobe, committed at the clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Host interrupt |

## Verification
The bench builds the block with its default parameters: seven blocks of eight inputs per master and group bases 0x130 and 0x1B0. With these values the first and last sources (index 0 and 111), the highest block's clear address that aliases onto the mask region boundary, and the clear addresses that alias onto the next block's pending address can all be reached directly. Cascade propagation from master 1 into master 0 bit 0 is exercised together with a master 0 block, so the combined summary value is checked.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int BLK_W      = 3;
  localparam int GROUP_SPAN = 32;
  localparam int OFF_CLR    = 1;
  localparam int OFF_MASK   = 8;
  localparam int OFF_RT     = 15;

  typedef enum logic [2:0] {
    RK_NONE = 3'd0,
    RK_SUM  = 3'd1,
    RK_PEND = 3'd2,
    RK_MASK = 3'd3,
    RK_RT   = 3'd4,
    RK_CLR  = 3'd5
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic             mst;
    logic [BLK_W-1:0] blk;
  } reg_sel_t;

  // flat source index of bit 'bitn' in block 'blk1' (1-based) of master 'mst'
  function automatic int src_index(input int mst, input int blk1, input int bitn,
                                   input int nb, input int sw);
    return ((mst * nb + blk1 - 1) * sw) + bitn;
  endfunction

  // offset of an address inside a master group, -1 when outside both groups
  function automatic int group_off(input logic [ADDR_W-1:0] addr, input int base0,
                                   input int base1, output logic mst);
    int a;
    a   = int'(addr);
    mst = 1'b0;
    if (a >= base0 && a < base0 + GROUP_SPAN) return a - base0;
    if (a >= base1 && a < base1 + GROUP_SPAN) begin
      mst = 1'b1;
      return a - base1;
    end
    return -1;
  endfunction

  function automatic reg_sel_t decode_rd(input logic [ADDR_W-1:0] addr, input int base0,
                                         input int base1, input int nb);
    reg_sel_t s;
    logic     m;
    int       off;
    s     = '0;
    off   = group_off(addr, base0, base1, m);
    s.mst = m;
    if (off == 0) begin
      s.kind = RK_SUM;
    end else if (off >= 1 && off <= nb) begin
      s.kind = RK_PEND;
      s.blk  = BLK_W'(off - 1);
    end else if (off > OFF_MASK && off <= OFF_MASK + nb) begin
      s.kind = RK_MASK;
      s.blk  = BLK_W'(off - OFF_MASK - 1);
    end else if (off > OFF_RT && off <= OFF_RT + nb) begin
      s.kind = RK_RT;
      s.blk  = BLK_W'(off - OFF_RT - 1);
    end
    return s;
  endfunction

  function automatic reg_sel_t decode_wr(input logic [ADDR_W-1:0] addr, input int base0,
                                         input int base1, input int nb);
    reg_sel_t s;
    logic     m;
    int       off;
    s     = '0;
    off   = group_off(addr, base0, base1, m);
    s.mst = m;
    if (off > OFF_CLR && off <= OFF_CLR + nb) begin
      s.kind = RK_CLR;
      s.blk  = BLK_W'(off - OFF_CLR - 1);
    end else if (off > OFF_MASK && off <= OFF_MASK + nb) begin
      s.kind = RK_MASK;
      s.blk  = BLK_W'(off - OFF_MASK - 1);
    end
    return s;
  endfunction

endpackage

// File: rtl/cic_block.sv
module cic_block #(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] src_i,
  input  logic          clr_we_i,
  input  logic          mask_we_i,
  input  logic [SW-1:0] wdata_i,
  output logic [SW-1:0] latched_o,
  output logic [SW-1:0] mask_o,
  output logic [SW-1:0] pend_o,
  output logic          any_o
);

  logic [SW-1:0] src_q;
  logic [SW-1:0] edge_w;
  logic [SW-1:0] clr_w;

  assign edge_w = src_i & ~src_q;
  assign clr_w  = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q     <= '0;
      latched_o <= '0;
      mask_o    <= '1;
    end else begin
      src_q     <= src_i;
      latched_o <= (latched_o & ~clr_w) | edge_w;
      if (mask_we_i) mask_o <= wdata_i;
    end
  end

  assign pend_o = latched_o & ~mask_o;
  assign any_o  = |pend_o;

  // R2: a detected edge is latched on the next cycle
  assert_edge_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_w != '0) |=> ((latched_o & $past(edge_w)) == $past(edge_w)));

  // R2: no latched bit appears without an edge
  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((latched_o & ~$past(latched_o) & ~$past(edge_w)) == '0));

  // R3 / R11: cleared bits drop unless a new edge arrives alongside
  assert_clear_effect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((latched_o & $past(wdata_i & ~edge_w)) == '0));

  // R4 / R10: the mask only moves on its own write strobe
  assert_mask_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we_i |=> $stable(mask_o));

endmodule

// File: rtl/cic_master.sv
module cic_master #(
  parameter int NB = 7
) (
  input  logic [NB-1:0] blk_any_i,
  input  logic          cascade_i,
  output logic [NB:0]   sum_o
);

  assign sum_o = {blk_any_i, cascade_i};

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cic_pkg::*;
#(
  parameter int NB    = 7,
  parameter int SW    = 8,
  parameter int BASE0 = 32'h130,
  parameter int BASE1 = 32'h1B0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*NB*SW-1:0]   src_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 irq_o
);

  localparam int NM = 2;

  reg_sel_t rsel;
  reg_sel_t wsel;

  logic [SW-1:0]         latch_w [NM][NB];
  logic [SW-1:0]         mask_w  [NM][NB];
  logic [SW-1:0]         pend_w  [NM][NB];
  logic [SW-1:0]         rt_w    [NM][NB];
  logic [NM-1:0][NB-1:0] blk_any;
  logic [NM-1:0][NB:0]   sum_w;

  assign rsel = decode_rd(reg_addr_i, BASE0, BASE1, NB);
  assign wsel = decode_wr(reg_addr_i, BASE0, BASE1, NB);

  for (genvar m = 0; m < NM; m++) begin : g_mst
    for (genvar b = 0; b < NB; b++) begin : g_blk
      localparam int LSB = src_index(m, b + 1, 0, NB, SW);
      logic sel_hit;
      logic any_w;

      assign sel_hit = reg_we_i && (wsel.mst == 1'(m)) && (wsel.blk == BLK_W'(b));
      assign rt_w[m][b] = src_i[LSB +: SW];

      cic_block #(.SW(SW)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i[LSB +: SW]),
        .clr_we_i  (sel_hit && (wsel.kind == RK_CLR)),
        .mask_we_i (sel_hit && (wsel.kind == RK_MASK)),
        .wdata_i   (SW'(reg_wdata_i)),
        .latched_o (latch_w[m][b]),
        .mask_o    (mask_w[m][b]),
        .pend_o    (pend_w[m][b]),
        .any_o     (any_w)
      );
      assign blk_any[m][b] = any_w;
    end

    logic casc_w;
    if (m == 0) begin : g_casc
      assign casc_w = |sum_w[1][NB:1];
    end else begin : g_nocasc
      assign casc_w = 1'b0;
    end

    cic_master #(.NB(NB)) u_mst (
      .blk_any_i (blk_any[m]),
      .cascade_i (casc_w),
      .sum_o     (sum_w[m])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (rsel.kind)
      RK_SUM:  reg_rdata_o = DATA_W'(sum_w[rsel.mst]);
      RK_PEND: reg_rdata_o = DATA_W'(pend_w[rsel.mst][rsel.blk]);
      RK_MASK: reg_rdata_o = DATA_W'(mask_w[rsel.mst][rsel.blk]);
      RK_RT:   reg_rdata_o = DATA_W'(rt_w[rsel.mst][rsel.blk]);
      default: reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |sum_w[0];

  // R8: host line only when some block somewhere has pending bits
  assert_irq_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (blk_any != '0));

  // R7: any pending block, in either master, reaches the host line
  assert_pend_reaches_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_any != '0) |-> irq_o);

  // R7: master 1 activity shows up as the cascade flag
  assert_cascade_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|sum_w[1][NB:1]) |-> sum_w[0][0]);

  // R10: a latched bit sits in exactly one state group, writes cannot reach it elsewhere
  assert_latch_no_phantom_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_we_i && src_i == '0) |=> (latch_w[0][0] & ~$past(latch_w[0][0])) == '0);

endmodule

// File: tb/cascade_irq_ctrl_bench.sv
module cascade_irq_ctrl_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NB = 7;
  localparam int SW = 8;
  localparam int NSRC = 2 * NB * SW;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_SRC = 2'd2;
  localparam int NV = 46;

  // op, requirement, address (or source index), data, expected read, expected irq
  localparam logic [38:0] VEC [NV] = '{
    {OP_RD,  4'd1,  16'h0139, 8'h00, 8'hFF, 1'b0},  // R1 mask reset
    {OP_RD,  4'd1,  16'h0131, 8'h00, 8'h00, 1'b0},  // R1
    {OP_RD,  4'd1,  16'h01B0, 8'h00, 8'h00, 1'b0},  // R1
    {OP_SRC, 4'd2,  16'd0,    8'h01, 8'h00, 1'b0},  // R2 source 0 rises
    {OP_RD,  4'd4,  16'h0131, 8'h00, 8'h00, 1'b0},  // R4 masked
    {OP_RD,  4'd5,  16'h0140, 8'h00, 8'h01, 1'b0},  // R5 live level
    {OP_WR,  4'd4,  16'h0139, 8'hFE, 8'h00, 1'b0},  // R4 unmask bit 0
    {OP_RD,  4'd4,  16'h0139, 8'h00, 8'hFE, 1'b1},  // R4 readback
    {OP_RD,  4'd4,  16'h0131, 8'h00, 8'h01, 1'b1},  // R4 latched while masked
    {OP_RD,  4'd6,  16'h0130, 8'h00, 8'h02, 1'b1},  // R6
    {OP_SRC, 4'd2,  16'd0,    8'h00, 8'h00, 1'b0},  // R2 source falls
    {OP_RD,  4'd2,  16'h0131, 8'h00, 8'h01, 1'b1},  // R2 sticky
    {OP_RD,  4'd5,  16'h0140, 8'h00, 8'h00, 1'b1},  // R5
    {OP_WR,  4'd3,  16'h0132, 8'h00, 8'h00, 1'b0},  // R3 zero write
    {OP_RD,  4'd3,  16'h0131, 8'h00, 8'h01, 1'b1},  // R3 no effect
    {OP_WR,  4'd3,  16'h0132, 8'h01, 8'h00, 1'b0},  // R3 clear
    {OP_RD,  4'd3,  16'h0131, 8'h00, 8'h00, 1'b0},  // R3
    {OP_RD,  4'd8,  16'h0130, 8'h00, 8'h00, 1'b0},  // R8
    {OP_WR,  4'd4,  16'h01BF, 8'h7F, 8'h00, 1'b0},  // R4 m1 b7 bit7 unmask
    {OP_SRC, 4'd9,  16'd111,  8'h01, 8'h00, 1'b0},  // R9 last source
    {OP_RD,  4'd9,  16'h01B7, 8'h00, 8'h80, 1'b1},  // R9
    {OP_RD,  4'd6,  16'h01B0, 8'h00, 8'h80, 1'b1},  // R6
    {OP_RD,  4'd7,  16'h0130, 8'h00, 8'h01, 1'b1},  // R7 cascade
    {OP_RD,  4'd5,  16'h01C6, 8'h00, 8'h80, 1'b1},  // R5
    {OP_WR,  4'd10, 16'h01B0, 8'hFF, 8'h00, 1'b0},  // R10 write summary
    {OP_WR,  4'd10, 16'h01B1, 8'hFF, 8'h00, 1'b0},  // R10 write pending b1
    {OP_WR,  4'd10, 16'h01C6, 8'hFF, 8'h00, 1'b0},  // R10 write live level
    {OP_RD,  4'd10, 16'h01B7, 8'h00, 8'h80, 1'b1},  // R10
    {OP_RD,  4'd10, 16'h01BF, 8'h00, 8'h7F, 1'b1},  // R10
    {OP_WR,  4'd3,  16'h01B8, 8'h80, 8'h00, 1'b0},  // R3 clear m1 b7
    {OP_RD,  4'd3,  16'h01B7, 8'h00, 8'h00, 1'b0},  // R3
    {OP_RD,  4'd7,  16'h0130, 8'h00, 8'h00, 1'b0},  // R7
    {OP_RD,  4'd10, 16'h0138, 8'h00, 8'h00, 1'b0},  // R10 clear addr reads 0
    {OP_RD,  4'd10, 16'h0000, 8'h00, 8'h00, 1'b0},  // R10
    {OP_RD,  4'd10, 16'h01AF, 8'h00, 8'h00, 1'b0},  // R10
    {OP_WR,  4'd4,  16'h013B, 8'h00, 8'h00, 1'b0},  // R4 m0 b3 unmask
    {OP_SRC, 4'd9,  16'd21,   8'h01, 8'h00, 1'b0},  // R9 m0 b3 bit5
    {OP_RD,  4'd9,  16'h0133, 8'h00, 8'h20, 1'b1},  // R9
    {OP_RD,  4'd6,  16'h0130, 8'h00, 8'h08, 1'b1},  // R6
    {OP_WR,  4'd4,  16'h01B9, 8'h00, 8'h00, 1'b0},  // R4 m1 b1 unmask
    {OP_SRC, 4'd9,  16'd58,   8'h01, 8'h00, 1'b0},  // R9 m1 b1 bit2
    {OP_RD,  4'd9,  16'h01B1, 8'h00, 8'h04, 1'b1},  // R9
    {OP_RD,  4'd7,  16'h0130, 8'h00, 8'h09, 1'b1},  // R7 both
    {OP_WR,  4'd4,  16'h01B9, 8'hFF, 8'h00, 1'b0},  // R4 remask
    {OP_RD,  4'd4,  16'h01B1, 8'h00, 8'h00, 1'b1},  // R4
    {OP_RD,  4'd7,  16'h0130, 8'h00, 8'h08, 1'b1}   // R7
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NSRC-1:0]  src;
  logic [15:0]      addr;
  logic             we;
  logic [7:0]       wdata;
  logic [7:0]       rdata;
  logic             irq;
  int               n_chk = 0;
  int               n_bad = 0;
  bit               done = 1'b0;

  always #2.5 clk = ~clk;

  cascade_irq_ctrl u_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input logic exp_irq,
                        input int req);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp || irq !== exp_irq) begin
      n_bad++;
      $display("FAIL R%0d addr %h: got data %h irq %b, expected data %h irq %b",
               req, a, rdata, irq, exp, exp_irq);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    src = '0; addr = '0; we = 1'b0; wdata = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][38:37];
      @(negedge clk);
      we = 1'b0;
      case (op)
        OP_WR:  begin addr = VEC[i][32:17]; wdata = VEC[i][16:9]; we = 1'b1; end
        OP_SRC: src[VEC[i][32:17]] = VEC[i][9];
        default: rd_chk(VEC[i][32:17], VEC[i][8:1], VEC[i][0], int'(VEC[i][36:33]));
      endcase
    end
    @(negedge clk);
    we = 1'b0;

    // R11: edge on bit1 and clear of bits 1:0 in the same cycle (m0 b2, sources 8,9)
    wr(16'h013A, 8'h00);
    src[8] = 1'b1;
    @(negedge clk);
    src[8] = 1'b0;
    @(negedge clk);
    src[9] = 1'b1;
    addr = 16'h0133; wdata = 8'h03; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    rd_chk(16'h0132, 8'h02, 1'b1, 11);

    // R1: reset returns every block to its initial state
    src = '0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      for (int b = 1; b <= NB; b++) begin
        logic [15:0] g;
        g = (m == 0) ? 16'h0130 : 16'h01B0;
        rd_chk(g + 16'(b) + 16'h8, 8'hFF, 1'b0, 1);
        rd_chk(g + 16'(b), 8'h00, 1'b0, 1);
      end
    end
    rd_chk(16'h0130, 8'h00, 1'b0, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule